// File: doc/BRIEF.md
# Ternary Test Vector Merger

This block combines two sets of three-valued scan test vectors into one set that can be broadcast to two cores at once. Each position of a vector is 0, 1 or don't-care. For each vector of the first set, the block looks through the second set for a vector that does not conflict with it, and emits the position-by-position merge of the two. A first-set vector with no partner goes out on its own. Once every first-set vector has been handled, the second-set vectors that were never taken go out unchanged. The number of vectors emitted is the size of the combined set.

Both sets sit in memories outside the block. The block drives a read address into each one and expects the word for that address on the same cycle. Its own registers hold the vector lengths, the search indices, a flag per second-set vector and the output vector. A vector pair is compared in one clock cycle. A small state machine runs the search as a sequential loop.

Results leave on a valid/ready stream. `out_valid` stays high, and `out_vec` stays unchanged, until the cycle in which `out_ready` is high. That cycle is the transfer. While the stream is stalled, the search does not advance.

Top module: `tvm_merger`

## Requirements
- R1: Each position uses two bits, and position p sits at bits [2p+1:2p]. If the upper bit is 1, the position is don't-care (X); otherwise the lower bit is the value. Two vectors are compatible when every position is equal in both or X in at least one.
- R2: A merged position takes the specified value when exactly one side is X, takes the common value when both sides are specified, and is X (encoded 10) when both sides are X.
- R3: For each first-set vector, candidates are tried at second-set indices 0, 1, 2 and so on, in order. The first candidate that is both compatible and not yet used is chosen.
- R4: A second-set vector taken by a merge is marked used. No later first-set vector can choose it, even if that vector is compatible with it.
- R5: A first-set vector with no eligible partner is emitted unchanged, apart from padding.
- R6: The first set has POS_A positions and the second set has POS_B. The narrower vectors are padded with X (10) in their upper positions up to the wider width, and every output has that wider width.
- R7: After all first-set vectors, the second-set vectors never used are emitted unchanged, in increasing index order.
- R8: While `out_valid` is high and `out_ready` is low, on the next cycle `out_valid` stays high and `out_vec` is unchanged.
- R9: `merged_count` goes up by one for each transfer and holds otherwise. `done` rises only after the last transfer, never coincides with `out_valid`, and `merged_count` then equals the number of vectors emitted.
- R10: `start` is taken only while the block is idle or done. It latches `num_a` and `num_b`, clears the count and the used flags, and drops `done` on the next cycle. Either set may be empty (length 0).
- R11: After reset, `done`, `out_valid` and `merged_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a merge run |
| num_a | input | $clog2(DEPTH_A)+1 | Number of first-set vectors (at most DEPTH_A) |
| num_b | input | $clog2(DEPTH_B)+1 | Number of second-set vectors (at most DEPTH_B) |
| a_addr | output | $clog2(DEPTH_A) | Read address into the first-set memory |
| a_rdata | input | 2*POS_A | First-set word at a_addr, same cycle |
| b_addr | output | $clog2(DEPTH_B) | Read address into the second-set memory |
| b_rdata | input | 2*POS_B | Second-set word at b_addr, same cycle |
| out_valid | output | 1 | Output vector is valid |
| out_ready | input | 1 | Sink accepts the output vector |
| out_vec | output | 2*max(POS_A,POS_B) | Merged, passed-through or appended vector |
| done | output | 1 | All vectors emitted; held until the next start |
| merged_count | output | $clog2(DEPTH_A+DEPTH_B+1) | Vectors transferred in this run |

## Verification
Two things can happen in the same cycle. The sink can stall the output while the search has an eligible partner available on the memory ports, and the final transfer can coincide with the move into the tail scan or into done. The bench applies pseudo-random back-pressure and checks that a stalled vector stays unchanged. It also checks that the vectors transferred match, in order, the lists expected from R1 to R7, and that `done` and the count settle only after the last transfer. The same stimulus table runs once with the sink always ready and once stalled, and both runs must produce the same expected lists.

// File: rtl/tvm_pkg.sv
package tvm_pkg;
  // Canonical encoding of a don't-care position.
  localparam logic [1:0] TERN_X = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_EMIT,
    ST_TAIL,
    ST_DONE
  } tvm_state_e;
endpackage

// File: rtl/tvm_pad.sv
module tvm_pad
  import tvm_pkg::*;
#(
  parameter int IN_POS  = 4,
  parameter int OUT_POS = 6
) (
  input  logic [2*IN_POS-1:0]  din,
  output logic [2*OUT_POS-1:0] dout
);
  for (genvar p = 0; p < OUT_POS; p++) begin : g_pos
    if (p < IN_POS) begin : g_copy
      assign dout[2*p +: 2] = din[2*p +: 2];
    end else begin : g_fill
      assign dout[2*p +: 2] = TERN_X;
    end
  end
endmodule

// File: rtl/tvm_pair_merge.sv
module tvm_pair_merge
  import tvm_pkg::*;
#(
  parameter int POS = 6
) (
  input  logic [2*POS-1:0] vec_a,
  input  logic [2*POS-1:0] vec_b,
  output logic             compat,
  output logic [2*POS-1:0] merged
);
  logic [POS-1:0] pos_ok;

  for (genvar p = 0; p < POS; p++) begin : g_pos
    logic [1:0] ea, eb;
    assign ea = vec_a[2*p +: 2];
    assign eb = vec_b[2*p +: 2];
    assign pos_ok[p] = ea[1] | eb[1] | (ea[0] == eb[0]);
    assign merged[2*p +: 2] = (ea[1] && eb[1]) ? TERN_X :
                              ea[1]            ? {1'b0, eb[0]} :
                                                 {1'b0, ea[0]};
  end

  assign compat = &pos_ok;
endmodule

// File: rtl/tvm_ctrl.sv
module tvm_ctrl
  import tvm_pkg::*;
#(
  parameter int DEPTH_A = 16,
  parameter int DEPTH_B = 16,
  parameter int POS     = 16,
  localparam int AW = (DEPTH_A > 1) ? $clog2(DEPTH_A) : 1,
  localparam int BW = (DEPTH_B > 1) ? $clog2(DEPTH_B) : 1,
  localparam int CW = $clog2(DEPTH_A + DEPTH_B + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW:0]      n_a,
  input  logic [BW:0]      n_b,
  input  logic [2*POS-1:0] a_vec,
  input  logic [2*POS-1:0] b_vec,
  input  logic             compat,
  input  logic [2*POS-1:0] merged,
  output logic [AW-1:0]    a_addr,
  output logic [BW-1:0]    b_addr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2*POS-1:0] out_vec,
  output logic             done,
  output logic [CW-1:0]    count
);
  localparam logic [AW:0]   A_ONE = (AW+1)'(1);
  localparam logic [BW:0]   B_ONE = (BW+1)'(1);
  localparam logic [CW-1:0] C_ONE = CW'(1);

  tvm_state_e         state;
  logic [AW:0]        a_idx, na_q;
  logic [BW:0]        b_idx, nb_q;
  logic [DEPTH_B-1:0] used;
  logic               in_tail;
  logic               b_end;
  logic               b_free;

  assign a_addr    = a_idx[AW-1:0];
  assign b_addr    = b_idx[BW-1:0];
  assign b_end     = (b_idx == nb_q);
  assign b_free    = !used[b_idx[BW-1:0]];
  assign out_valid = (state == ST_EMIT);
  assign done      = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      a_idx   <= '0;
      b_idx   <= '0;
      na_q    <= '0;
      nb_q    <= '0;
      used    <= '0;
      in_tail <= 1'b0;
      out_vec <= '0;
      count   <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            na_q    <= n_a;
            nb_q    <= n_b;
            a_idx   <= '0;
            b_idx   <= '0;
            used    <= '0;
            count   <= '0;
            in_tail <= (n_a == '0);
            state   <= (n_a == '0) ? ST_TAIL : ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (b_end) begin
            out_vec <= a_vec;
            state   <= ST_EMIT;
          end else if (b_free && compat) begin
            out_vec                <= merged;
            used[b_idx[BW-1:0]]    <= 1'b1;
            state                  <= ST_EMIT;
          end else begin
            b_idx <= b_idx + B_ONE;
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            count <= count + C_ONE;
            if (in_tail) begin
              b_idx <= b_idx + B_ONE;
              state <= ST_TAIL;
            end else if ((a_idx + A_ONE) == na_q) begin
              b_idx   <= '0;
              in_tail <= 1'b1;
              state   <= ST_TAIL;
            end else begin
              a_idx <= a_idx + A_ONE;
              b_idx <= '0;
              state <= ST_SEARCH;
            end
          end
        end
        ST_TAIL: begin
          if (b_end) begin
            state <= ST_DONE;
          end else if (b_free) begin
            out_vec <= b_vec;
            state   <= ST_EMIT;
          end else begin
            b_idx <= b_idx + B_ONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tvm_merger.sv
module tvm_merger #(
  parameter int POS_A   = 12,
  parameter int POS_B   = 16,
  parameter int DEPTH_A = 16,
  parameter int DEPTH_B = 16,
  localparam int POS = (POS_A > POS_B) ? POS_A : POS_B,
  localparam int AW  = (DEPTH_A > 1) ? $clog2(DEPTH_A) : 1,
  localparam int BW  = (DEPTH_B > 1) ? $clog2(DEPTH_B) : 1,
  localparam int CW  = $clog2(DEPTH_A + DEPTH_B + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW:0]      num_a,
  input  logic [BW:0]      num_b,
  output logic [AW-1:0]    a_addr,
  input  logic [2*POS_A-1:0] a_rdata,
  output logic [BW-1:0]    b_addr,
  input  logic [2*POS_B-1:0] b_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2*POS-1:0] out_vec,
  output logic             done,
  output logic [CW-1:0]    merged_count
);
  logic [2*POS-1:0] a_vec, b_vec, merged;
  logic             compat;

  tvm_pad #(.IN_POS(POS_A), .OUT_POS(POS)) u_pad_a (.din(a_rdata), .dout(a_vec));
  tvm_pad #(.IN_POS(POS_B), .OUT_POS(POS)) u_pad_b (.din(b_rdata), .dout(b_vec));

  tvm_pair_merge #(.POS(POS)) u_merge (
    .vec_a (a_vec),
    .vec_b (b_vec),
    .compat(compat),
    .merged(merged)
  );

  tvm_ctrl #(.DEPTH_A(DEPTH_A), .DEPTH_B(DEPTH_B), .POS(POS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .n_a      (num_a),
    .n_b      (num_b),
    .a_vec    (a_vec),
    .b_vec    (b_vec),
    .compat   (compat),
    .merged   (merged),
    .a_addr   (a_addr),
    .b_addr   (b_addr),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_vec  (out_vec),
    .done     (done),
    .count    (merged_count)
  );
endmodule

// File: rtl/tvm_merger_chk.sv
module tvm_merger_chk #(
  parameter int VEC_W = 12,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_vec,
  input logic             done,
  input logic [CNT_W-1:0] merged_count
);
  // R8: a stalled vector is held
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec)));

  // R9: one count step per transfer
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (merged_count == $past(merged_count) + CNT_W'(1)));

  // R9: count holds without a transfer or a start
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(out_valid && out_ready) && !start) |=> $stable(merged_count));

  // R9: done and valid never together
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  // R10: start drops done on the next cycle
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done);
endmodule

bind tvm_merger tvm_merger_chk #(.VEC_W(2*POS), .CNT_W(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_vec     (out_vec),
  .done        (done),
  .merged_count(merged_count)
);

// File: tb/tvm_merger_bench.sv
module tvm_merger_bench;
  localparam int PA = 4, PB = 6, DA = 4, DB = 4, POS = 6;
  localparam int NC = 6, ME = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, start, out_ready, out_valid, done;
  logic [2:0]       num_a, num_b;
  logic [1:0]       a_addr, b_addr;
  logic [2*PA-1:0]  a_rdata;
  logic [2*PB-1:0]  b_rdata;
  logic [2*POS-1:0] out_vec;
  logic [3:0]       merged_count;

  logic [2*PA-1:0] mem_a [DA];
  logic [2*PB-1:0] mem_b [DB];
  assign a_rdata = mem_a[a_addr];
  assign b_rdata = mem_b[b_addr];

  tvm_merger #(.POS_A(PA), .POS_B(PB), .DEPTH_A(DA), .DEPTH_B(DB)) u_tvm_merger (
    .clk(clk), .rst_n(rst_n), .start(start), .num_a(num_a), .num_b(num_b),
    .a_addr(a_addr), .a_rdata(a_rdata), .b_addr(b_addr), .b_rdata(b_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec),
    .done(done), .merged_count(merged_count)
  );

  // Ternary entries as {xmask[5:0], value[5:0]}; first-set entries already show X padding.
  localparam int T_NA [NC] = '{2, 2, 0, 2, 0, 4};
  localparam int T_NB [NC] = '{2, 2, 2, 0, 0, 4};
  localparam int T_NE [NC] = '{3, 2, 2, 2, 0, 4};
  localparam logic [11:0] T_A [NC][4] = '{
    '{12'b110010_000101, 12'b110000_001111, 12'h0, 12'h0},
    '{12'b111111_000000, 12'b111111_000000, 12'h0, 12'h0},
    '{12'h0, 12'h0, 12'h0, 12'h0},
    '{12'b110000_000000, 12'b110101_001010, 12'h0, 12'h0},
    '{12'h0, 12'h0, 12'h0, 12'h0},
    '{12'b110000_000000, 12'b110000_000001, 12'b110000_001111, 12'b111110_000001}
  };
  localparam logic [11:0] T_B [NC][4] = '{
    '{12'b000000_110001, 12'b001000_100101, 12'h0, 12'h0},
    '{12'b000000_000000, 12'b000100_111011, 12'h0, 12'h0},
    '{12'b010101_000000, 12'b010101_101010, 12'h0, 12'h0},
    '{12'h0, 12'h0, 12'h0, 12'h0},
    '{12'h0, 12'h0, 12'h0, 12'h0},
    '{12'b110000_000001, 12'b000000_000000, 12'b100000_011111, 12'b010110_000001}
  };
  localparam logic [11:0] T_E [NC][ME] = '{
    '{12'b000000_100101, 12'b110000_001111, 12'b000000_110001, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0},
    '{12'b000000_000000, 12'b000100_111011, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0},
    '{12'b010101_000000, 12'b010101_101010, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0},
    '{12'b110000_000000, 12'b110101_001010, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0},
    '{12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0},
    '{12'b000000_000000, 12'b110000_000001, 12'b100000_011111, 12'b010110_000001,
      12'h0, 12'h0, 12'h0, 12'h0}
  };

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] lfsr = 8'hA5;

  function automatic logic [11:0] enc(input logic [11:0] t);
    logic [11:0] e;
    for (int p = 0; p < 6; p++) begin
      e[2*p+1] = t[6+p];
      e[2*p]   = t[6+p] ? 1'b0 : t[p];
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
      $finish;
    end
  end

  // One table case: R1..R7 through the vector lists, R8 stall hold, R9/R10 end of run.
  task automatic run_case(input int c, input bit bp);
    int idx;
    bit stalled;
    logic [2*POS-1:0] prev;
    logic [11:0] e;
    for (int i = 0; i < DA; i++) begin e = enc(T_A[c][i]); mem_a[i] = e[7:0]; end
    for (int i = 0; i < DB; i++) mem_b[i] = enc(T_B[c][i]);
    num_a = 3'(T_NA[c]);
    num_b = 3'(T_NB[c]);
    out_ready = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R10 done drops after start", 32'(done), 0);
    idx = 0;
    stalled = 0;
    prev = '0;
    for (int k = 0; k < 400 && !done; k++) begin
      if (stalled)
        check(out_valid && out_vec == prev, "R8 stalled vector held", 32'(out_vec), 32'(prev));
      if (bp) begin
        out_ready = lfsr[0] | lfsr[3];
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end else out_ready = 1'b1;
      if (out_valid && out_ready) begin
        if (idx < T_NE[c])
          check(out_vec == enc(T_E[c][idx]), "R1 R2 R3 R4 R5 R6 R7 vector", 32'(out_vec), 32'(enc(T_E[c][idx])));
        else
          check(1'b0, "R7 extra vector", 32'(idx), 32'(T_NE[c]));
        idx++;
      end
      stalled = out_valid && !out_ready;
      prev = out_vec;
      @(negedge clk);
    end
    check(done == 1'b1, "R9 done reached", 32'(done), 1);
    check(out_valid == 1'b0, "R9 no valid with done", 32'(out_valid), 0);
    check(merged_count == 4'(T_NE[c]), "R9 count", 32'(merged_count), 32'(T_NE[c]));
    check(idx == T_NE[c], "R9 vectors transferred", 32'(idx), 32'(T_NE[c]));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b0; num_a = '0; num_b = '0;
    for (int i = 0; i < DA; i++) mem_a[i] = '0;
    for (int i = 0; i < DB; i++) mem_b[i] = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(done == 1'b0, "R11 done in reset", 32'(done), 0);
    check(out_valid == 1'b0, "R11 valid in reset", 32'(out_valid), 0);
    check(merged_count == '0, "R11 count in reset", 32'(merged_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && out_valid == 1'b0, "R11 idle after reset", 32'({done, out_valid}), 0);
    // Table walk: sink always ready, then with back-pressure (R8).
    for (int pass = 0; pass < 2; pass++)
      for (int c = 0; c < NC; c++)
        run_case(c, pass == 1);
    // R10: done and count hold while no start arrives.
    repeat (5) @(negedge clk);
    check(done == 1'b1 && merged_count == 4'd4, "R10 done held without start", 32'({done, merged_count}), 32'h14);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule